// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches 16-bit words from a small three-wire serial configuration EEPROM. It drives the memory's select, clock and serial-input pins, and samples its serial-output pin. A host issues a request carrying a word address and an address-width choice. The block builds the read command, shifts it out, clocks the data word back in and presents it on a result port. The length of each serial clock phase is set at run time in system clock cycles.

A second kind of request loads an identity value. The block first reads word 0 with 8-bit addressing to learn which address width the attached memory uses. It then reads three consecutive words starting at word 7 with that width, back to back. The three words come out as one 48-bit value with a single valid pulse.

The request port uses a valid/ready handshake. The block raises `req_ready` only while it is idle, so a request held during an access simply waits. Results are pulses with no back-pressure. The host must capture `rd_data` or `ident_mac` when the pulse appears, or later, since both hold until the next result of their own kind.

Top module: `sprom_reader`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when `busy` is low. A request presented while busy is ignored and does not disturb the access in progress.
- R2: Every serial phase (pin state) lasts max(`phase_len`,1) system clocks, so a `phase_len` of 0 behaves as 1.
- R3: An access opens with one phase of select low and clock low, then one phase of select high with clock low and data-in low. The clock is never high while select is low.
- R4: The command is binary 110 followed by the word address, sent MSB first. It is 11 bits with the 8-bit address when `req_wide`=1, or 9 bits with the low 6 address bits when `req_wide`=0. Each bit goes on data-in for a low clock phase and is held through the following high clock phase.
- R5: After the command, one phase has select high, clock low and data-in low. Then come 16 high/low clock pulse pairs with data-in low. `ee_do` is sampled at the end of each high phase, and the first sample is the word's MSB.
- R6: The access closes with one phase of select low and clock low.
- R7: For a plain read, `rd_valid` is high for exactly one cycle, the cycle after the closing phase, in which `busy` is already low. `rd_data` holds the word until the next plain read completes and is not altered by identity loads.
- R8: An identity load (`req_ident`=1) first reads word 0 with 8-bit addressing. It selects 8-bit addressing if that word equals 0x8129 and 6-bit otherwise. `wide_detected` shows the choice from the end of that read onward.
- R9: The identity load then reads words 7, 8 and 9 with the selected width. The four accesses follow each other with no idle cycle between them. `ident_mac` = {word9, word8, word7}, so byte 0 (bits 7:0) is the low byte of word 7 and byte 1 (bits 15:8) is its high byte.
- R10: `ident_valid` is high for one cycle, the cycle after the last closing phase. `ident_mac` changes only in that cycle and is not altered by plain reads.
- R11: After reset, select, clock and data-in are low, `busy` is low, and `rd_valid`, `rd_data`, `ident_valid`, `ident_mac` and `wide_detected` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_len | input | DIV_W | System clocks per serial phase (0 treated as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_ident | input | 1 | 1 = identity load, 0 = plain word read |
| req_wide | input | 1 | Plain read addressing: 1 = 8-bit, 0 = 6-bit |
| req_addr | input | WIDE_AW | Word address for a plain read |
| busy | output | 1 | An access is in progress |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` updated |
| rd_data | output | DATA_W | Last word from a plain read |
| ident_valid | output | 1 | One-cycle pulse: `ident_mac` updated |
| ident_mac | output | ID_WORDS*DATA_W | Assembled identity value |
| wide_detected | output | 1 | Result of the last width detection |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The bench builds the block with its default parameters: an 8-bit phase length field, 16-bit words, 6- and 8-bit addressing, signature 0x8129, and identity words 7 to 9. The phase length is swept at run time through 0, 1, 2 and 3, which brings the minimum-length clamp and multi-cycle phases within reach. A behavioural memory model of either address width sits on the pins. Its 6-bit variant turns the width probe into a misaligned read that must not match the signature, and its 8-bit variant makes the probe succeed.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  // read opcode including the always-one leading bit
  localparam logic [2:0] RD_OP = 3'b110;

  typedef enum logic [3:0] {
    E_IDLE,
    E_PRE,   // select low, clock low
    E_SEL,   // select high, clock low
    E_CLO,   // command bit, clock low
    E_CHI,   // command bit, clock high
    E_GAP,   // data-in back to 0
    E_DHI,   // data clock high, sample at end
    E_DLO,   // data clock low
    E_END    // select low
  } eng_st_t;

  typedef enum logic [1:0] {
    Q_IDLE,
    Q_SINGLE,
    Q_DET,
    Q_ID
  } seq_st_t;

endpackage

// File: rtl/sprom_tick.sv
module sprom_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] phase_len,
  input  logic             active,
  input  logic             restart,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (phase_len == '0) ? '0 : phase_len - DIV_W'(1);
  assign tick = active && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !active || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/sprom_engine.sv
module sprom_engine
  import sprom_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NARROW_AW = 6,
  parameter int WIDE_AW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               go,
  input  logic [WIDE_AW-1:0] go_addr,
  input  logic               go_wide,
  input  logic               ee_do,
  output logic               active,
  output logic               done,
  output logic [DATA_W-1:0]  word,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di
);

  localparam int CMD_W = 3 + WIDE_AW;
  localparam int PAD   = WIDE_AW - NARROW_AW;
  localparam int MAXN  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W = $clog2(MAXN + 1);

  eng_st_t            st;
  logic [CMD_W-1:0]   cmd_sr;
  logic [CNT_W-1:0]   left;
  logic [DATA_W-1:0]  data_sr;
  logic [CMD_W-1:0]   cmd_wide;
  logic [CMD_W-1:0]   cmd_narrow;
  logic [CMD_W-1:0]   go_cmd;
  logic [CNT_W-1:0]   go_len;
  logic               load;

  assign cmd_wide = {RD_OP, go_addr};

  // narrow commands are left-aligned so the MSB always leaves first
  generate
    if (PAD > 0) begin : g_pad
      assign cmd_narrow = {RD_OP, go_addr[NARROW_AW-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign cmd_narrow = cmd_wide;
    end
  endgenerate

  assign go_cmd = go_wide ? cmd_wide : cmd_narrow;
  assign go_len = go_wide ? CNT_W'(CMD_W) : CNT_W'(CMD_W - PAD);
  assign done   = (st == E_END) && tick;
  assign load   = go && ((st == E_IDLE) || done);
  assign active = (st != E_IDLE);
  assign word   = data_sr;

  assign ee_cs = (st == E_SEL) || (st == E_CLO) || (st == E_CHI) ||
                 (st == E_GAP) || (st == E_DHI) || (st == E_DLO);
  assign ee_sk = (st == E_CHI) || (st == E_DHI);
  assign ee_di = ((st == E_CLO) || (st == E_CHI)) && cmd_sr[CMD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      cmd_sr  <= '0;
      left    <= '0;
      data_sr <= '0;
    end else if (load) begin
      st     <= E_PRE;
      cmd_sr <= go_cmd;
      left   <= go_len;
    end else if (tick) begin
      case (st)
        E_PRE: st <= E_SEL;
        E_SEL: st <= E_CLO;
        E_CLO: st <= E_CHI;
        E_CHI: begin
          cmd_sr <= cmd_sr << 1;
          left   <= left - CNT_W'(1);
          st     <= (left == CNT_W'(1)) ? E_GAP : E_CLO;
        end
        E_GAP: begin
          left <= CNT_W'(DATA_W);
          st   <= E_DHI;
        end
        E_DHI: begin
          data_sr <= {data_sr[DATA_W-2:0], ee_do};
          st      <= E_DLO;
        end
        E_DLO: begin
          left <= left - CNT_W'(1);
          st   <= (left == CNT_W'(1)) ? E_END : E_DHI;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
  import sprom_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          WIDE_AW  = 8,
  parameter int          ID_BASE  = 7,
  parameter int          ID_WORDS = 3,
  parameter logic [15:0] SIG      = 16'h8129
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_ident,
  input  logic                         req_wide,
  input  logic [WIDE_AW-1:0]           req_addr,
  output logic                         req_ready,
  output logic                         busy,
  input  logic                         done,
  input  logic [DATA_W-1:0]            word,
  output logic                         go,
  output logic [WIDE_AW-1:0]           go_addr,
  output logic                         go_wide,
  output logic                         rd_valid,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         ident_valid,
  output logic [ID_WORDS*DATA_W-1:0]   ident_mac,
  output logic                         wide_detected
);

  localparam int IDX_W = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;
  localparam int MAC_W = ID_WORDS * DATA_W;

  seq_st_t                 q;
  logic [IDX_W-1:0]        idx;
  logic [DATA_W-1:0]       shadow [ID_WORDS-1];
  logic [MAC_W-1:0]        mac_next;
  logic                    sig_hit;
  logic                    last;

  assign sig_hit   = (word == DATA_W'(SIG));
  assign last      = (idx == IDX_W'(ID_WORDS - 1));
  assign req_ready = (q == Q_IDLE);
  assign busy      = (q != Q_IDLE);

  // earlier words from the shadow, final word straight from the engine
  generate
    for (genvar k = 0; k < ID_WORDS - 1; k++) begin : g_mac
      assign mac_next[k*DATA_W +: DATA_W] = shadow[k];
    end
  endgenerate
  assign mac_next[(ID_WORDS-1)*DATA_W +: DATA_W] = word;

  always_comb begin
    go      = 1'b0;
    go_addr = '0;
    go_wide = 1'b0;
    case (q)
      Q_IDLE: begin
        if (req_valid) begin
          go = 1'b1;
          if (req_ident) begin
            go_addr = '0;
            go_wide = 1'b1;
          end else begin
            go_addr = req_addr;
            go_wide = req_wide;
          end
        end
      end
      Q_DET: begin
        if (done) begin
          go      = 1'b1;
          go_addr = WIDE_AW'(ID_BASE);
          go_wide = sig_hit;
        end
      end
      Q_ID: begin
        if (done && !last) begin
          go      = 1'b1;
          go_addr = WIDE_AW'(ID_BASE) + WIDE_AW'(idx) + WIDE_AW'(1);
          go_wide = wide_detected;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q             <= Q_IDLE;
      idx           <= '0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      ident_valid   <= 1'b0;
      ident_mac     <= '0;
      wide_detected <= 1'b0;
      for (int k = 0; k < ID_WORDS - 1; k++) shadow[k] <= '0;
    end else begin
      rd_valid    <= 1'b0;
      ident_valid <= 1'b0;
      case (q)
        Q_IDLE: begin
          if (req_valid) q <= req_ident ? Q_DET : Q_SINGLE;
        end
        Q_SINGLE: begin
          if (done) begin
            rd_data  <= word;
            rd_valid <= 1'b1;
            q        <= Q_IDLE;
          end
        end
        Q_DET: begin
          if (done) begin
            wide_detected <= sig_hit;
            idx           <= '0;
            q             <= Q_ID;
          end
        end
        Q_ID: begin
          if (done) begin
            if (last) begin
              ident_mac   <= mac_next;
              ident_valid <= 1'b1;
              q           <= Q_IDLE;
            end else begin
              shadow[idx] <= word;
              idx         <= idx + IDX_W'(1);
            end
          end
        end
        default: q <= Q_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sprom_reader.sv
module sprom_reader #(
  parameter int          DIV_W     = 8,
  parameter int          DATA_W    = 16,
  parameter int          NARROW_AW = 6,
  parameter int          WIDE_AW   = 8,
  parameter int          ID_BASE   = 7,
  parameter int          ID_WORDS  = 3,
  parameter logic [15:0] SIG       = 16'h8129
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DIV_W-1:0]           phase_len,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_ident,
  input  logic                       req_wide,
  input  logic [WIDE_AW-1:0]         req_addr,
  output logic                       busy,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       ident_valid,
  output logic [ID_WORDS*DATA_W-1:0] ident_mac,
  output logic                       wide_detected,
  output logic                       ee_cs,
  output logic                       ee_sk,
  output logic                       ee_di,
  input  logic                       ee_do
);

  logic               tick;
  logic               eng_active;
  logic               eng_done;
  logic [DATA_W-1:0]  eng_word;
  logic               go;
  logic [WIDE_AW-1:0] go_addr;
  logic               go_wide;

  sprom_tick #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_len (phase_len),
    .active    (eng_active),
    .restart   (go),
    .tick      (tick)
  );

  sprom_engine #(
    .DATA_W    (DATA_W),
    .NARROW_AW (NARROW_AW),
    .WIDE_AW   (WIDE_AW)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .go      (go),
    .go_addr (go_addr),
    .go_wide (go_wide),
    .ee_do   (ee_do),
    .active  (eng_active),
    .done    (eng_done),
    .word    (eng_word),
    .ee_cs   (ee_cs),
    .ee_sk   (ee_sk),
    .ee_di   (ee_di)
  );

  sprom_seq #(
    .DATA_W   (DATA_W),
    .WIDE_AW  (WIDE_AW),
    .ID_BASE  (ID_BASE),
    .ID_WORDS (ID_WORDS),
    .SIG      (SIG)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ident     (req_ident),
    .req_wide      (req_wide),
    .req_addr      (req_addr),
    .req_ready     (req_ready),
    .busy          (busy),
    .done          (eng_done),
    .word          (eng_word),
    .go            (go),
    .go_addr       (go_addr),
    .go_wide       (go_wide),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .ident_valid   (ident_valid),
    .ident_mac     (ident_mac),
    .wide_detected (wide_detected)
  );

endmodule

// File: rtl/sprom_reader_chk.sv
module sprom_reader_chk #(
  parameter int MAC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             rd_valid,
  input logic             ident_valid,
  input logic [MAC_W-1:0] ident_mac,
  input logic             ee_cs,
  input logic             ee_sk,
  input logic             ee_di
);

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  assert_sk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  assert_di_held_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> $stable(ee_di));

  assert_idle_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_di));

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_rd_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy);

  assert_ident_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ident_valid |=> !ident_valid);

  assert_mac_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ident_mac) |-> ident_valid);

endmodule

bind sprom_reader sprom_reader_chk #(.MAC_W(ID_WORDS*DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .busy        (busy),
  .rd_valid    (rd_valid),
  .ident_valid (ident_valid),
  .ident_mac   (ident_mac),
  .ee_cs       (ee_cs),
  .ee_sk       (ee_sk),
  .ee_di       (ee_di)
);

// File: tb/sprom_reader_tb.sv
module sprom_reader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  phase_len = 8'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_ident = 1'b0;
  logic        req_wide = 1'b0;
  logic [7:0]  req_addr = 8'd0;
  logic        busy;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        ident_valid;
  logic [47:0] ident_mac;
  logic        wide_detected;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;

  always #5 clk = ~clk;

  sprom_reader u_dut (
    .clk(clk), .rst_n(rst_n), .phase_len(phase_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_ident(req_ident),
    .req_wide(req_wide), .req_addr(req_addr), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .ident_valid(ident_valid),
    .ident_mac(ident_mac), .wide_detected(wide_detected),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int total = 0;
  int bad   = 0;
  int dev_aw = 8;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  // expected per-cycle state: {busy, cs, sk, di, rd_valid, ident_valid}
  logic [5:0]  exp_q[$];
  logic [15:0] exp_rd = 16'd0;
  logic [47:0] exp_mac = 48'd0;
  bit          exp_wide = 1'b0;

  function automatic logic [15:0] memval(int i);
    if (i == 0) return 16'h8129;
    return 16'((i * 32'h1357) ^ 32'hA5C3);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // behavioural memory on the serial pins, evaluated between clock edges
  int          dstate = 0;
  int          dcnt = 0;
  int          didx = 0;
  logic [15:0] dcmd = 16'd0;
  logic [31:0] dword = 32'd0;
  logic        sk_q = 1'b0;

  always @(negedge clk) begin
    if (!ee_cs) begin
      dstate = 0; dcnt = 0; dcmd = 16'd0; ee_do = 1'b0;
    end else if (ee_sk && !sk_q) begin
      case (dstate)
        0: if (ee_di) begin dstate = 1; dcnt = 0; end
        1: begin
          dcmd = {dcmd[14:0], ee_di};
          dcnt++;
          if (dcnt == 2 + dev_aw) begin
            int a;
            int m;
            m = (1 << dev_aw) - 1;
            a = int'(dcmd) & m;
            dword = {memval(a), memval((a + 1) & m)};
            didx = 31;
            dstate = 2;
            ee_do = 1'b0;
          end
        end
        default: begin
          ee_do = (didx >= 0) ? dword[didx] : 1'b0;
          didx--;
        end
      endcase
    end
    sk_q = ee_sk;
  end

  function automatic int eff_len();
    return (phase_len == 8'd0) ? 1 : int'(phase_len);
  endfunction

  task automatic push_n(bit cs, bit sk, bit di, int n);
    for (int i = 0; i < n; i++) exp_q.push_back({1'b1, cs, sk, di, 2'b00});
  endtask

  task automatic push_access(int addr, bit wide);
    int aw;
    int nb;
    int L;
    logic [10:0] cmd;
    aw = wide ? 8 : 6;
    nb = 3 + aw;
    L = eff_len();
    cmd = 11'((6 << aw) | (addr & ((1 << aw) - 1)));
    push_n(0, 0, 0, L);
    push_n(1, 0, 0, L);
    for (int i = nb - 1; i >= 0; i--) begin
      push_n(1, 0, cmd[i], L);
      push_n(1, 1, cmd[i], L);
    end
    push_n(1, 0, 0, L);
    for (int i = 0; i < 16; i++) begin
      push_n(1, 1, 0, L);
      push_n(1, 0, 0, L);
    end
    push_n(0, 0, 0, L);
  endtask

  // per-cycle comparison against the reference trace
  always @(negedge clk) begin
    if (mon_on && !finished) begin
      logic [5:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 6'd0;
      chk({busy, ee_cs, ee_sk, ee_di, rd_valid, ident_valid} == e,
          "trace R2 R3 R4 R5 R6 R9", 64'({busy, ee_cs, ee_sk, ee_di, rd_valid, ident_valid}), 64'(e));
      chk(req_ready == !e[5], "ready R1", 64'(req_ready), 64'(!e[5]));
      if (e[1]) chk(rd_data == exp_rd, "data R5 R7", 64'(rd_data), 64'(exp_rd));
      if (e[0]) begin
        chk(ident_mac == exp_mac, "mac R9", 64'(ident_mac), 64'(exp_mac));
        chk(wide_detected == exp_wide, "detect R8", 64'(wide_detected), 64'(exp_wide));
      end
    end
  end

  task automatic wait_idle();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic single(int addr, bit wide);
    int m;
    @(negedge clk);
    req_valid = 1'b1; req_ident = 1'b0; req_wide = wide; req_addr = 8'(addr);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    m = (1 << dev_aw) - 1;
    exp_rd = memval(addr & m);
    push_access(addr, wide);
    exp_q.push_back(6'b000010);
  endtask

  task automatic ident();
    bit w;
    logic [31:0] cat;
    int m;
    @(negedge clk);
    req_valid = 1'b1; req_ident = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_ident = 1'b0;
    if (dev_aw == 8) begin
      w = (memval(0) == 16'h8129);
    end else begin
      cat = {memval(0), memval(1)};
      w = (16'(cat >> 14) == 16'h8129);
    end
    m = (1 << dev_aw) - 1;
    exp_wide = w;
    exp_mac = {memval(9 & m), memval(8 & m), memval(7 & m)};
    push_access(0, 1'b1);
    push_access(7, w);
    push_access(8, w);
    push_access(9, w);
    exp_q.push_back(6'b000001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "reset pins R11", 64'({ee_cs, ee_sk, ee_di}), 64'd0);
    chk(busy == 1'b0 && req_ready == 1'b1, "reset busy R11", 64'({busy, req_ready}), 64'd1);
    chk(rd_valid == 1'b0 && rd_data == 16'd0, "reset rd R11", 64'({rd_valid, rd_data}), 64'd0);
    chk(ident_valid == 1'b0 && ident_mac == 48'd0 && wide_detected == 1'b0,
        "reset ident R11", 64'(ident_mac), 64'd0);
    mon_on = 1'b1;

    // R4 R5 R7: 8-bit plain read, one clock per phase
    dev_aw = 8; phase_len = 8'd1;
    single(8'h05, 1'b1);
    wait_idle();

    // R2: zero phase length acts as one
    phase_len = 8'd0;
    single(8'hC3, 1'b1);
    wait_idle();

    // R4 R1: 6-bit read with three-clock phases and a request while busy
    dev_aw = 6; phase_len = 8'd3;
    single(8'h2A, 1'b0);
    repeat (12) @(negedge clk);
    req_valid = 1'b1; req_ident = 1'b1; req_addr = 8'hFF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(req_ready == 1'b0 && busy == 1'b1, "busy ignores request R1", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0; req_ident = 1'b0;
    wait_idle();

    // R8 R9 R10: identity load on an 8-bit device, two clocks per phase
    dev_aw = 8; phase_len = 8'd2;
    ident();
    wait_idle();
    chk(rd_data == memval(16'h2A), "rd_data held over ident R7", 64'(rd_data), 64'(memval(16'h2A)));
    chk(wide_detected == 1'b1, "detect wide R8", 64'(wide_detected), 64'd1);

    // R7 R10: plain read leaves the identity value alone
    phase_len = 8'd1;
    single(8'h11, 1'b1);
    wait_idle();
    chk(ident_mac == exp_mac, "mac held over read R10", 64'(ident_mac), 64'(exp_mac));

    // R8 R9: identity load on a 6-bit device
    dev_aw = 6;
    ident();
    wait_idle();
    chk(wide_detected == 1'b0, "detect narrow R8", 64'(wide_detected), 64'd0);
    chk(ident_mac[7:0] == memval(7)[7:0], "mac byte order R9", 64'(ident_mac[7:0]), 64'(memval(7)[7:0]));

    // R6 R7: two plain reads back to back
    single(8'h3F, 1'b0);
    wait_idle();
    single(8'h00, 1'b0);
    wait_idle();

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule